// File: doc/BRIEF.md
# Cellular Automaton Lottery Number Generator

This block draws lottery numbers in the range 0 to 20. It has a 64-cell one-dimensional cellular automaton as its random source. Every clock cycle all cells update together. Each cell's next value depends on its own value and on the values of its two neighbours. Cells at even positions follow the three-input XOR rule (rule 150). Cells at odd positions follow the two-neighbour XOR rule (rule 90). A neighbour position that lies past either end of the array always reads as zero.

The user can load a 64-bit seed into the cell array at any time. A seed of zero never evolves, so the block replaces it with a fixed nonzero default. When a draw is requested, a small sequencer reduces the full 64-bit cell state modulo 21 on three consecutive cycles. It then presents the three results together on its outputs and pulses a completion flag for one cycle.

Top module: `ca_lotto_top`

## Requirements
- R1: After reset, the three number outputs and `draw_done` are 0, and the cell state equals the default seed 64'h9E3779B97F4A7C15.
- R2: When `seed_load` is high at a clock edge, the cell state becomes `seed_value` at that edge. If `seed_value` is zero, the cell state becomes the default seed instead.
- R3: At every clock edge without a load, each cell i takes the XOR of cell i+1 and cell i-1, with cells outside 0..63 reading as 0. Cell i also XORs in its own value when i is even.
- R4: If `draw_req` is high at an edge while no draw is in progress, that edge and the next two edges capture the state visible just before each edge, reduced modulo 21. The results go to `num_a`, `num_b` and `num_c` in that order.
- R5: Every number output is an unsigned 5-bit value from 0 to 20, equal to the 64-bit unsigned remainder of the captured state divided by 21.
- R6: `draw_done` is high for exactly the one cycle after the third capture. The number outputs change only at the edge that raises `draw_done`, and they hold their values at all other times.
- R7: `draw_req` is ignored while a draw is in progress. It starts no new draw and does not alter the draw that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_load | input | 1 | Load `seed_value` into the cell array |
| seed_value | input | 64 | Seed for the cell array (zero selects the default) |
| draw_req | input | 1 | Request a three-number draw |
| num_a | output | 5 | First number of the last draw |
| num_b | output | 5 | Second number of the last draw |
| num_c | output | 5 | Third number of the last draw |
| draw_done | output | 1 | One-cycle pulse when a draw's numbers are valid |

## Verification
The cell state cannot be observed at the ports. An error in it still shows up in the very next draw, because each number is a modulo-21 image of the full state. A wrong cell rule or wrong boundary handling gives a wrong `num_b` or `num_c` within two cycles of the request, even when `num_a` is correct. A wrong seed handling or a wrong reset value already corrupts `num_a` of the first draw. An error in the sequencer's count shows at the ports as `draw_done` rising one cycle early or late, or as numbers that change outside the completion edge.

// File: rtl/ca_lotto_pkg.sv
package ca_lotto_pkg;
  localparam int CELLS   = 64;
  localparam int MODULUS = 21;
  localparam int NUM_W   = 5;
  localparam int DRAWS   = 3;
  localparam int MOD_W   = NUM_W + 1;

  localparam logic [CELLS-1:0] RULE150_MASK = 64'h5555_5555_5555_5555;
  localparam logic [CELLS-1:0] DEFAULT_SEED = 64'h9E37_79B9_7F4A_7C15;

  // One cell update: the two neighbours always, self only for rule 150.
  function automatic logic cell_rule(input logic left, input logic self_v,
                                     input logic right, input logic use150);
    return left ^ right ^ (use150 & self_v);
  endfunction

  // Bit-serial remainder: r stays below MODULUS, so 2r+1 fits in MOD_W bits.
  function automatic logic [NUM_W-1:0] mod_reduce(input logic [CELLS-1:0] v);
    logic [MOD_W-1:0] r;
    r = '0;
    for (int i = CELLS - 1; i >= 0; i--) begin
      r = {r[NUM_W-1:0], v[i]};
      if (r >= MOD_W'(MODULUS)) r = r - MOD_W'(MODULUS);
    end
    return r[NUM_W-1:0];
  endfunction
endpackage

// File: rtl/ca_cell_array.sv
module ca_cell_array
  import ca_lotto_pkg::*;
#(
  parameter int               N_CELLS  = CELLS,
  parameter logic [N_CELLS-1:0] MASK150 = RULE150_MASK,
  parameter logic [N_CELLS-1:0] DEF_SEED = DEFAULT_SEED
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CELLS-1:0] seed,
  output logic [N_CELLS-1:0] state,
  output logic               seed_zero
);
  logic [N_CELLS-1:0] nxt;
  logic [N_CELLS-1:0] load_val;

  assign seed_zero = (seed == '0);
  assign load_val  = seed_zero ? DEF_SEED : seed;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic lft, rgt;
    if (i == N_CELLS - 1) begin : g_top_edge
      assign lft = 1'b0;
    end else begin : g_top_in
      assign lft = state[i+1];
    end
    if (i == 0) begin : g_bot_edge
      assign rgt = 1'b0;
    end else begin : g_bot_in
      assign rgt = state[i-1];
    end
    assign nxt[i] = cell_rule(lft, state[i], rgt, MASK150[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= DEF_SEED;
    else if (load) state <= load_val;
    else           state <= nxt;
  end
endmodule

// File: rtl/mod_reducer.sv
module mod_reducer
  import ca_lotto_pkg::*;
#(
  parameter int IN_W  = CELLS,
  parameter int OUT_W = NUM_W
) (
  input  logic [IN_W-1:0]  value,
  output logic [OUT_W-1:0] residue
);
  assign residue = OUT_W'(mod_reduce(CELLS'(value)));
endmodule

// File: rtl/draw_seq.sv
module draw_seq
  import ca_lotto_pkg::*;
#(
  parameter int W     = NUM_W,
  parameter int COUNT = DRAWS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    draw_req,
  input  logic [W-1:0]            value,
  output logic                    busy,
  output logic                    accept,
  output logic                    done,
  output logic [COUNT-1:0][W-1:0] nums
);
  localparam int CNT_W = (COUNT > 1) ? $clog2(COUNT) : 1;
  typedef enum logic {S_IDLE, S_COLLECT} seq_t;

  seq_t                     st;
  logic [CNT_W-1:0]         idx;
  logic [COUNT-1:0][W-1:0]  slot;
  logic                     last_cap;

  assign busy     = (st == S_COLLECT);
  assign accept   = (st == S_IDLE) && draw_req;
  assign last_cap = busy && (idx == CNT_W'(COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      slot <= '0;
      nums <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        slot[0] <= value;
        idx     <= CNT_W'(1);
        st      <= S_COLLECT;
      end else if (busy) begin
        slot[idx] <= value;
        idx       <= idx + 1'b1;
        if (last_cap) begin
          for (int k = 0; k < COUNT - 1; k++) nums[k] <= slot[k];
          nums[COUNT-1] <= value;
          done          <= 1'b1;
          st            <= S_IDLE;
          idx           <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ca_lotto_top.sv
module ca_lotto_top
  import ca_lotto_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [CELLS-1:0] seed_value,
  input  logic             draw_req,
  output logic [NUM_W-1:0] num_a,
  output logic [NUM_W-1:0] num_b,
  output logic [NUM_W-1:0] num_c,
  output logic             draw_done
);
  logic [CELLS-1:0]            ca_state;
  logic                        seed_zero;
  logic [NUM_W-1:0]            residue;
  logic                        seq_busy;
  logic                        seq_accept;
  logic [DRAWS-1:0][NUM_W-1:0] nums;

  ca_cell_array #(.N_CELLS(CELLS), .MASK150(RULE150_MASK), .DEF_SEED(DEFAULT_SEED)) u_cells (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_value),
    .state(ca_state), .seed_zero(seed_zero)
  );

  mod_reducer #(.IN_W(CELLS), .OUT_W(NUM_W)) u_mod (
    .value(ca_state), .residue(residue)
  );

  draw_seq #(.W(NUM_W), .COUNT(DRAWS)) u_seq (
    .clk(clk), .rst_n(rst_n), .draw_req(draw_req), .value(residue),
    .busy(seq_busy), .accept(seq_accept), .done(draw_done), .nums(nums)
  );

  assign num_a = nums[0];
  assign num_b = nums[1];
  assign num_c = nums[2];
endmodule

// File: rtl/ca_lotto_chk.sv
module ca_lotto_chk
  import ca_lotto_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic [CELLS-1:0] seed_value,
  input logic [CELLS-1:0] ca_state,
  input logic             seq_busy,
  input logic             seq_accept,
  input logic             draw_req,
  input logic [NUM_W-1:0] num_a,
  input logic [NUM_W-1:0] num_b,
  input logic [NUM_W-1:0] num_c,
  input logic             draw_done
);
  function automatic logic [CELLS-1:0] shift_step(input logic [CELLS-1:0] s);
    return (s << 1) ^ (s >> 1) ^ (s & RULE150_MASK);
  endfunction

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && (seed_value != '0) |=> ca_state == $past(seed_value));
  p_zero_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && (seed_value == '0) |=> ca_state == DEFAULT_SEED);
  p_cell_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> ca_state == shift_step($past(ca_state)));
  p_never_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ca_state != '0);
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done |-> $past(seq_busy));
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (num_a < NUM_W'(MODULUS)) && (num_b < NUM_W'(MODULUS)) && (num_c < NUM_W'(MODULUS)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done |=> !draw_done);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !draw_done |-> $stable(num_a) && $stable(num_b) && $stable(num_c));
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy && draw_req |-> !seq_accept);
endmodule

bind ca_lotto_top ca_lotto_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
  .ca_state(ca_state), .seq_busy(seq_busy), .seq_accept(seq_accept),
  .draw_req(draw_req), .num_a(num_a), .num_b(num_b), .num_c(num_c),
  .draw_done(draw_done)
);

// File: tb/sim_ca_lotto_top.sv
module sim_ca_lotto_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [63:0] seed_value = '0;
  logic        draw_req = 1'b0;
  logic [4:0]  num_a, num_b, num_c;
  logic        draw_done;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [63:0] MASK_EVEN = 64'h5555_5555_5555_5555;
  localparam logic [63:0] DEF       = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk; // 50 MHz

  ca_lotto_top u0 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .draw_req(draw_req), .num_a(num_a), .num_b(num_b), .num_c(num_c),
    .draw_done(draw_done)
  );

  // Reference model of the cell state, written as whole-word shifts.
  function automatic logic [63:0] ref_step(input logic [63:0] s);
    return (s << 1) ^ (s >> 1) ^ (s & MASK_EVEN);
  endfunction
  function automatic logic [4:0] ref_mod(input logic [63:0] s);
    return 5'(s % 64'd21);
  endfunction

  logic [63:0] m_state;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)         m_state <= DEF;
    else if (seed_load) m_state <= (seed_value == 0) ? DEF : seed_value;
    else                m_state <= ref_step(m_state);
  end

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issue a request at this negedge; check results three edges later.
  task automatic run_draw(input string req);
    logic [63:0] s0, s1, s2;
    s0 = m_state; s1 = ref_step(s0); s2 = ref_step(s1);
    draw_req = 1'b1;
    @(negedge clk); draw_req = 1'b0;
    check(req, "done early 1", 64'(draw_done), 64'd0);
    @(negedge clk);
    check(req, "done early 2", 64'(draw_done), 64'd0);
    @(negedge clk);
    check(req, "done", 64'(draw_done), 64'd1);
    check(req, "num_a", 64'(num_a), 64'(ref_mod(s0)));
    check(req, "num_b", 64'(num_b), 64'(ref_mod(s1)));
    check(req, "num_c", 64'(num_c), 64'(ref_mod(s2)));
    @(negedge clk);
    check("R6", "done pulse width", 64'(draw_done), 64'd0);
  endtask

  task automatic load_seed(input logic [63:0] s);
    seed_load = 1'b1; seed_value = s;
    @(negedge clk);
    seed_load = 1'b0; seed_value = '0;
  endtask

  task automatic t_reset();
    check("R1", "num_a reset", 64'(num_a), 64'd0);
    check("R1", "num_b reset", 64'(num_b), 64'd0);
    check("R1", "num_c reset", 64'(num_c), 64'd0);
    check("R1", "done reset", 64'(draw_done), 64'd0);
    rst_n = 1'b1;            // state still DEF until the next edge
    run_draw("R1");          // numbers come from DEF and its successors
  endtask

  task automatic t_seeds();
    load_seed(64'h0000_0000_0000_0001); run_draw("R3");
    load_seed(64'h8000_0000_0000_0000); run_draw("R3");
    load_seed(64'hFFFF_FFFF_FFFF_FFFF); run_draw("R2");
    load_seed(64'h0123_4567_89AB_CDEF); run_draw("R4");
  endtask

  task automatic t_zero_seed();
    logic [4:0] e0;
    e0 = ref_mod(DEF);
    load_seed(64'h0);
    check("R2", "model state after zero seed", m_state, DEF);
    run_draw("R2");
    check("R2", "zero seed first number", 64'(num_a), 64'(e0));
  endtask

  task automatic t_back_to_back();
    load_seed(64'hDEAD_BEEF_0BAD_F00D);
    run_draw("R4");
    repeat (5) @(negedge clk);
    run_draw("R4");
  endtask

  task automatic t_busy_ignore();
    logic [63:0] s0;
    logic [4:0]  ea, eb, ec;
    load_seed(64'h1357_9BDF_2468_ACE0);
    s0 = m_state;
    ea = ref_mod(s0); eb = ref_mod(ref_step(s0)); ec = ref_mod(ref_step(ref_step(s0)));
    draw_req = 1'b1;              // held high across the whole draw
    @(negedge clk);
    check("R7", "no done while busy 1", 64'(draw_done), 64'd0);
    @(negedge clk);
    check("R7", "no done while busy 2", 64'(draw_done), 64'd0);
    @(negedge clk);
    draw_req = 1'b0;
    check("R7", "done", 64'(draw_done), 64'd1);
    check("R7", "num_a", 64'(num_a), 64'(ea));
    check("R7", "num_b", 64'(num_b), 64'(eb));
    check("R7", "num_c", 64'(num_c), 64'(ec));
    repeat (4) begin
      @(negedge clk);
      check("R6", "outputs held num_a", 64'(num_a), 64'(ea));
      check("R6", "outputs held num_c", 64'(num_c), 64'(ec));
      check("R6", "no stray done", 64'(draw_done), 64'd0);
    end
  endtask

  task automatic t_range_sweep();
    for (int k = 0; k < 24; k++) begin
      load_seed({$urandom(), $urandom()});
      run_draw("R5");
      check("R5", "num_a range", 64'(num_a < 5'd21), 64'd1);
      check("R5", "num_b range", 64'(num_b < 5'd21), 64'd1);
      check("R5", "num_c range", 64'(num_c < 5'd21), 64'd1);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_seeds();
    t_zero_seed();
    t_back_to_back();
    t_busy_ignore();
    t_range_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule